// File: doc/BRIEF.md
# Word-to-Port Serializer

This block takes 32-bit words from an internal queue through a valid/ready handshake. It sends each word out over a narrow output port, one beat per clock. At run time the port is either 16 bits wide, giving two beats per word, or 8 bits wide, giving four beats per word. Beats go out lowest part first. In 16-bit mode the low byte lane carries bits 7:0 and then 23:16. When a word holds Y/C samples as Cb, Y0, Cr, Y1, those are the chroma bytes.

The output stream may have gaps. A qualifier pin marks each cycle that holds a valid beat. When a configuration input is set, the same pin instead gives a clock pulse only for cycles that hold a valid beat. A receiver with few pins can then capture data on that pulse's rising edge. The port width is fixed for each word at the moment the word is accepted. The qualifier mode may only be changed while the block is idle.

Top module: `dword_port_serializer`

## Requirements
- R1: While reset is asserted, and right after it is released, `inReady` is 1, `portQual` is 0 and `portData` is 0.
- R2: A word is taken at a rising edge where `inValid` and `inReady` are both 1. Its first beat is on `portData` during the very next cycle. While `inValid` is low, no word is taken and the port stays idle.
- R3: With `narrowMode`=0 a word goes out in two consecutive cycles: `portData` = bits 15:0, then bits 31:16.
- R4: With `narrowMode`=1 a word goes out in four consecutive cycles: `portData[7:0]` = bits 7:0, 15:8, 23:16, 31:24 in that order, and `portData[15:8]` = 0.
- R5: `inReady` is 0 during every beat except the last beat of a word. It is 1 during the last beat and when idle, so words offered back to back go out with no gap.
- R6: With `gateClkMode`=0, `portQual` is 1 exactly in the cycles that hold a beat. In every other cycle `portQual` is 0 and `portData` is 0.
- R7: The width used for a word is the value of `narrowMode` at its accepting edge. Changes to `narrowMode` during the word have no effect on that word.
- R8: With `gateClkMode`=1, `portQual` is 0 throughout each low phase of `clk`. In a high phase it follows `clk` exactly when the cycle that ended at that rising edge held a beat. `gateClkMode` is changed only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous reset, active low |
| narrowMode | input | 1 | 1 = 8-bit port, 0 = 16-bit port |
| gateClkMode | input | 1 | 1 = qualifier pin is a gated clock |
| inData | input | 32 | Word from the queue |
| inValid | input | 1 | Word offered |
| inReady | output | 1 | Word may be taken this cycle |
| portData | output | 16 | Output beat, low byte lane in bits 7:0 |
| portQual | output | 1 | Data qualifier or gated clock |

## Verification
Two events can fall in the same cycle: the last beat of one word goes out while the next word is accepted. When that happens, the new word's first beat must follow with no gap and no lost or repeated beat. The bench provokes this by offering words with zero, one and two idle cycles between them, in both widths and in both qualifier modes. In one sweep it also flips the width input every cycle, so the width change coincides with beats and with accepting edges. A scoreboard of expected beats, filled only when a handshake is seen, judges every cycle's data, qualifier and ready level.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef struct packed {
    logic load;       // take a new word into the hold register
    logic shift;      // move to the next beat
    logic narrow;     // width of the word in flight
    logic beatValid;  // a beat is on the port this cycle
  } dpsStrobes_t;
endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int PORT_LANES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        narrowMode,
  input  logic        gateClkMode,
  input  logic        inValid,
  output logic        inReady,
  output dpsStrobes_t stb,
  output logic        portQual
);
  localparam int IDX_W      = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WIDE_BEATS = LANES / PORT_LANES;

  logic             busy;
  logic             curNarrow;
  logic [IDX_W-1:0] beatIdx;
  logic             lastBeat;
  logic             accept;
  logic             qualEn;

  assign lastBeat = curNarrow ? (beatIdx == IDX_W'(LANES - 1))
                              : (beatIdx == IDX_W'(WIDE_BEATS - 1));
  assign inReady  = !busy || lastBeat;
  assign accept   = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      curNarrow <= 1'b0;
      beatIdx   <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      curNarrow <= narrowMode;
      beatIdx   <= '0;
    end else if (busy && lastBeat) begin
      busy    <= 1'b0;
      beatIdx <= '0;
    end else if (busy) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  always_comb begin
    stb.load      = accept;
    stb.shift     = busy && !lastBeat;
    stb.narrow    = curNarrow;
    stb.beatValid = busy;
  end

  // enable changes only while clk is low, so the gated pulse is never cut short
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) qualEn <= 1'b0;
    else       qualEn <= busy;
  end

  assign portQual = gateClkMode ? (clk && qualEn) : busy;

  AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBeat) |-> !inReady); // R5
  AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBeat) |=> (busy && beatIdx == IDX_W'($past(beatIdx) + 1'b1))); // R3
  AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBeat) |=> (curNarrow == $past(curNarrow))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !curNarrow) |-> (beatIdx < IDX_W'(WIDE_BEATS))); // R3
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!gateClkMode && !busy) |-> !portQual); // R6
  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && beatIdx == '0)); // R2
endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int LANES      = 4,
  parameter int PORT_LANES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpsStrobes_t                  stb,
  input  logic [LANE_W*LANES-1:0]      inData,
  output logic [LANE_W*PORT_LANES-1:0] portData
);
  localparam int WORD_W = LANE_W * LANES;
  localparam int PORT_W = LANE_W * PORT_LANES;

  logic [WORD_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdReg <= '0;
    else if (stb.load)  holdReg <= inData;
    else if (stb.shift) holdReg <= stb.narrow ? (holdReg >> LANE_W) : (holdReg >> PORT_W);
  end

  for (genvar g = 0; g < PORT_LANES; g++) begin : gLane
    if (g == 0) begin : gLow
      assign portData[LANE_W-1:0] = stb.beatValid ? holdReg[LANE_W-1:0] : '0;
    end else begin : gHigh
      assign portData[g*LANE_W +: LANE_W] =
        (stb.beatValid && !stb.narrow) ? holdReg[g*LANE_W +: LANE_W] : '0;
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (holdReg == $past(inData))); // R2
  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && !stb.narrow) |=> (holdReg[PORT_W-1:0] == $past(holdReg[2*PORT_W-1:PORT_W]))); // R3
  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && stb.narrow) |=> (holdReg[LANE_W-1:0] == $past(holdReg[2*LANE_W-1:LANE_W]))); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    stb.narrow |-> (portData[PORT_W-1:LANE_W] == '0)); // R4
endmodule

// File: rtl/dword_port_serializer.sv
module dword_port_serializer
  import dps_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int LANES      = 4,
  parameter int PORT_LANES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         narrowMode,
  input  logic                         gateClkMode,
  input  logic [LANE_W*LANES-1:0]      inData,
  input  logic                         inValid,
  output logic                         inReady,
  output logic [LANE_W*PORT_LANES-1:0] portData,
  output logic                         portQual
);
  dpsStrobes_t stb;

  dps_ctrl #(.LANES(LANES), .PORT_LANES(PORT_LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .narrowMode(narrowMode), .gateClkMode(gateClkMode),
    .inValid(inValid), .inReady(inReady), .stb(stb), .portQual(portQual)
  );

  dps_datapath #(.LANE_W(LANE_W), .LANES(LANES), .PORT_LANES(PORT_LANES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .portData(portData)
  );
endmodule

// File: tb/tb_dword_port_serializer.sv
module tb_dword_port_serializer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        narrowMode = 1'b0;
  logic        gateClkMode = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] portData;
  logic        portQual;

  int errors = 0;
  int checks = 0;
  bit monOn = 0;
  bit accSeen = 0;
  bit prevExpValid = 0;
  bit toggleMode = 0;
  bit modeReq = 0;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  dword_port_serializer dut (
    .clk(clk), .rstN(rstN), .narrowMode(narrowMode), .gateClkMode(gateClkMode),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .portData(portData), .portQual(portQual)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // single writer of narrowMode; toggles every cycle during the R7 sweep
  always @(negedge clk) narrowMode <= toggleMode ? ~narrowMode : modeReq;

  // sampled 2 ns before each rising edge
  always @(negedge clk) begin
    #8;
    if (monOn) begin
      bit expValid;
      expValid = expQ.size() > 0;
      chk(inReady == (expQ.size() <= 1), "R5 ready", {31'b0, inReady}, {31'b0, expQ.size() <= 1});
      if (gateClkMode) chk(portQual == 1'b0, "R8 low phase", {31'b0, portQual}, 32'd0);
      else             chk(portQual == expValid, "R6 qualifier", {31'b0, portQual}, {31'b0, expValid});
      if (expValid) begin
        chk(portData == expQ[0], toggleMode ? "R7 beat data" : "R3/R4 beat data", {16'b0, portData}, {16'b0, expQ[0]});
        void'(expQ.pop_front());
      end else begin
        chk(portData == 16'h0, "R6 idle data", {16'b0, portData}, 32'd0);
      end
      prevExpValid = expValid;
      accSeen = inValid && inReady;
      if (accSeen) begin  // R2: beats follow the accepting edge
        if (narrowMode) begin
          for (int b = 0; b < 4; b++) expQ.push_back({8'h00, inData[b*8 +: 8]});
        end else begin
          expQ.push_back(inData[15:0]);
          expQ.push_back(inData[31:16]);
        end
      end
    end
  end

  // high phase in gated-clock mode
  always @(posedge clk) begin
    #5;
    if (monOn && gateClkMode)
      chk(portQual == prevExpValid, "R8 high phase", {31'b0, portQual}, {31'b0, prevExpValid});
  end

  task automatic sendWord(input logic [31:0] d, input int gap);
    @(negedge clk);
    inValid = 1'b1;
    inData = d;
    do @(posedge clk); while (!accSeen);
    if (gap > 0) begin
      @(negedge clk);
      inValid = 1'b0;
      inData = 32'hDEAD_BEEF;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic finishRun();
    @(negedge clk);
    inValid = 1'b0;
    toggleMode = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    chk(inReady == 1'b1, "R1 reset ready", {31'b0, inReady}, 32'd1);
    chk(portQual == 1'b0, "R1 reset qualifier", {31'b0, portQual}, 32'd0);
    chk(portData == 16'h0, "R1 reset data", {16'b0, portData}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(portQual == 1'b0 && inReady == 1'b1, "R1 after reset", {30'b0, portQual, inReady}, 32'd1);
    monOn = 1;
    for (int g = 0; g < 2; g++) begin
      @(negedge clk);
      gateClkMode = g[0];  // idle here
      for (int m = 0; m < 3; m++) begin
        for (int gap = 0; gap < 3; gap++) begin
          modeReq = (m == 1);
          repeat (2) @(negedge clk);
          toggleMode = (m == 2);
          for (int w = 0; w < 6; w++) begin
            k++;
            sendWord(32'h9E37_79B9 * k ^ {k[7:0], 24'h0}, gap);
          end
          finishRun();
        end
      end
      repeat (4) @(negedge clk);
    end
    chk(expQ.size() == 0, "R2 all beats delivered", expQ.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule